// File: doc/BRIEF.md
# Latched-Address Write-Once Byte Memory

This block is a byte-wide memory whose bits can only be set, never cleared. It is meant for a multiplexed address/data bus: the caller presents an address and pulls chip-select low, and the block captures the address on the first clock edge that sees the select low. From then until the select goes high again the block serves that one word. Later activity on the address lines does not disturb it. Read data is registered and appears on a data-out bus. A separate drive-enable output tells the surrounding logic when the bus would be actively driven, so the block can stand in for a three-state pin group inside a larger synthesizable design.

Normal operation needs the program-mode pin held high. With the pin low, a selected access also accepts writes through a valid/ready handshake. A write merges its data into the stored word with a bitwise OR, so a 0 in the write data leaves the stored bit alone. When a write asks for a 1 to become a 0, that part of the request is dropped and a one-cycle flag reports the attempt. Back-pressure rule: `wr_ready` is high only while a selected access is under way with program mode active. A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high. With `wr_ready` low, `wr_valid` is ignored. Reset clears every word to zero.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset every word reads as 0x00, and `rd_oe`, `wr_ready` and `clr_flag` are all 0.
- R2: The address is captured on the first rising edge at which `ce_n` is sampled low after being high. Address changes after that edge do not change the word being read or written.
- R3: Read data for the captured address is on `rd_data` after the second rising edge that samples `ce_n` low. `rd_oe` is never high unless `ce_n` was low at the previous edge.
- R4: With `ce_n` low and `oe_n` high, `rd_oe` is 0. Pulling `oe_n` low then drives the already-valid data with no extra clock.
- R5: With `ce_n` high, `rd_oe` is 0 whatever the level of `oe_n`.
- R6: While `ce_n` stays low, no new address is captured. A new address needs `ce_n` to be high for at least one sampled edge.
- R7: `wr_ready` is 1 only while `pgm_n` is 0 and a selected access is under way. With `pgm_n` high, a write request leaves the stored word unchanged.
- R8: An accepted write stores the old word OR the write data. No stored 1 ever returns to 0 while the address stays latched.
- R9: `clr_flag` is 1 for exactly the cycle after an accepted write whose data has a 0 in a position where the stored word has a 1. Otherwise it is 0.
- R10: A write changes only the word at the latched address. The lowest and highest addresses are programmable like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the array |
| ce_n | input | 1 | Active-low chip select; the falling level starts an access |
| oe_n | input | 1 | Active-low output drive enable |
| pgm_n | input | 1 | Program mode when low; must be high for normal reads |
| addr | input | AW | Word address, captured at the start of an access |
| wr_valid | input | 1 | Write request valid |
| wr_data | input | DW | Bits to set in the latched word |
| wr_ready | output | 1 | Block can take a write this cycle |
| rd_data | output | DW | Registered read word |
| rd_oe | output | 1 | Read bus drive enable (stands in for three-state control) |
| clr_flag | output | 1 | One-cycle pulse: a write asked to clear a set bit |

## Verification
On every cycle, the assertions check the following relations: the drive enable never rises without select and output enable, the latched address holds steady through a long select, write readiness requires program mode, the clear flag follows an accepted write, and the stored word at a held address never loses a 1. Only the bench scenarios can show that the right word comes back from the right address. The same holds for the OR-merge producing the expected values and for address changes during an access being ignored. The same is true for writes without program mode leaving data untouched, for neighbouring and end addresses staying independent, and for reset wiping programmed contents.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic {
    ACC_IDLE  = 1'b0,
    ACC_HELD  = 1'b1
  } acc_state_e;
endpackage

// File: rtl/otp_addr_latch.sv
module otp_addr_latch
  import otp_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_lat,
  output logic          sel
);
  acc_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ACC_IDLE;
      addr_lat <= '0;
    end else begin
      case (state_q)
        ACC_IDLE: if (!ce_n) begin
          state_q  <= ACC_HELD;
          addr_lat <= addr_in;
        end
        ACC_HELD: if (ce_n) state_q <= ACC_IDLE;
        default:  state_q <= ACC_IDLE;
      endcase
    end
  end

  assign sel = (state_q == ACC_HELD);
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel,
  input  logic          ce_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic [DW-1:0] cur_word,
  output logic          clr_hit
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem[i] <= '0;
      else if (hit) mem[i] <= mem[i] | wdata;
    end
  end

  assign cur_word = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      clr_hit  <= 1'b0;
    end else begin
      rd_valid <= sel && !ce_n;
      if (sel) rdata <= cur_word;
      clr_hit  <= wr_en && (|(cur_word & ~wdata));
    end
  end
endmodule

// File: rtl/otp_out_gate.sv
module otp_out_gate (
  input  logic rd_valid,
  input  logic ce_n,
  input  logic oe_n,
  output logic drive
);
  assign drive = rd_valid && !ce_n && !oe_n;
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          clr_flag
);
  logic [AW-1:0] addr_lat;
  logic          sel;
  logic          rd_valid;
  logic          wr_en;
  logic [DW-1:0] cur_word;

  otp_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_in(addr),
    .addr_lat(addr_lat), .sel(sel)
  );

  assign wr_ready = sel && !ce_n && !pgm_n;
  assign wr_en    = wr_valid && wr_ready;

  otp_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(addr_lat), .sel(sel), .ce_n(ce_n),
    .wr_en(wr_en), .wdata(wr_data), .rdata(rd_data), .rd_valid(rd_valid),
    .cur_word(cur_word), .clr_hit(clr_flag)
  );

  otp_out_gate u_gate (
    .rd_valid(rd_valid), .ce_n(ce_n), .oe_n(oe_n), .drive(rd_oe)
  );
endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          pgm_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_oe,
  input logic          clr_flag,
  input logic [AW-1:0] addr_lat,
  input logic [DW-1:0] cur_word
);
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !oe_n); // R4
  AST_DRIVE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !ce_n); // R5
  AST_DRIVE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(!ce_n)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n) && $past(!ce_n, 2)) |-> $stable(addr_lat)); // R6
  AST_READY_NEEDS_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !pgm_n); // R7
  AST_NO_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr_lat) |-> ((cur_word & $past(cur_word)) == $past(cur_word))); // R8
  AST_FLAG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |-> $past(wr_valid && wr_ready)); // R9
endmodule

bind otp_latched_rom otp_latched_rom_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_oe(rd_oe),
  .clr_flag(clr_flag), .addr_lat(addr_lat), .cur_word(cur_word)
);

// File: tb/tb_otp_latched_rom.sv
`timescale 1ns/1ps
module tb_otp_latched_rom;
  localparam int AW = 11;
  localparam int DW = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] e;
    logic          c;
  } vec_t;

  // Writes use program mode; e is the read-back after the write, c the expected flag.
  localparam vec_t VECS [10] = '{
    '{1'b0, 11'd5,    8'h00, 8'h00, 1'b0},
    '{1'b1, 11'd5,    8'h0F, 8'h0F, 1'b0},
    '{1'b1, 11'd5,    8'hF0, 8'hFF, 1'b1},
    '{1'b1, 11'd5,    8'h00, 8'hFF, 1'b1},
    '{1'b1, 11'd6,    8'h81, 8'h81, 1'b0},
    '{1'b0, 11'd5,    8'h00, 8'hFF, 1'b0},
    '{1'b1, 11'd2047, 8'h3C, 8'h3C, 1'b0},
    '{1'b1, 11'd0,    8'h01, 8'h01, 1'b0},
    '{1'b0, 11'd4,    8'h00, 8'h00, 1'b0},
    '{1'b1, 11'd6,    8'h81, 8'h81, 1'b0}
  };

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ce_n = 1, oe_n = 0, pgm_n = 1, wr_valid = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_oe, clr_flag;
  logic [DW-1:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  otp_latched_rom #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .addr(addr), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_oe(rd_oe), .clr_flag(clr_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Access with a write in program mode; the address is scrambled after capture (R2).
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] e, input logic c);
    @(negedge clk); pgm_n = 0; ce_n = 0; addr = a;
    @(negedge clk); addr = ~a; wr_valid = 1; wr_data = d;
    #1 chk("R7 ready", wr_ready, 1);
    @(negedge clk); wr_valid = 0;
    chk("R9 flag", clr_flag, c);
    @(negedge clk);
    chk("R8 readback", rd_data, e);
    chk("R3 drive", rd_oe, 1);
    ce_n = 1; pgm_n = 1;
    @(negedge clk);
    chk("R9 flag one cycle", clr_flag, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
    @(negedge clk); ce_n = 0; addr = a;
    @(negedge clk); addr = ~a;
    @(negedge clk);
    chk("R2 R3 read", rd_data, e);
    chk("R3 drive", rd_oe, 1);
    ce_n = 1;
    #1 chk("R5 ce high", rd_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe at reset", rd_oe, 0);
    chk("R1 ready at reset", wr_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", clr_flag, 0);
    chk("R5 idle oe low", rd_oe, 0);

    foreach (VECS[i]) begin
      if (VECS[i].wr) do_write(VECS[i].a, VECS[i].d, VECS[i].e, VECS[i].c);
      else            do_read(VECS[i].a, VECS[i].e);
    end

    // R10: neighbours and end addresses
    do_read(11'd7, 8'h00);
    do_read(11'd2047, 8'h3C);
    do_read(11'd1, 8'h00);

    // R4: output enable held off, then released without a clock
    @(negedge clk); oe_n = 1; ce_n = 0; addr = 11'd6;
    repeat (2) @(negedge clk);
    chk("R4 oe high no drive", rd_oe, 0);
    oe_n = 0;
    #1 chk("R4 drive on oe low", rd_oe, 1);
    chk("R4 data", rd_data, 8'h81);
    ce_n = 1;

    // R6: hold select low while address moves
    @(negedge clk); ce_n = 0; addr = 11'd5;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      addr = 11'd6;
      @(negedge clk);
      chk("R6 held address", rd_data, 8'hFF);
    end
    ce_n = 1;
    do_read(11'd6, 8'h81);

    // R7: write without program mode is ignored
    @(negedge clk); ce_n = 0; addr = 11'd4;
    @(negedge clk); wr_valid = 1; wr_data = 8'hFF;
    #1 chk("R7 not ready", wr_ready, 0);
    @(negedge clk); wr_valid = 0;
    chk("R7 no flag", clr_flag, 0);
    @(negedge clk);
    chk("R7 unchanged", rd_data, 8'h00);
    ce_n = 1;

    // R1: reset clears programmed contents
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    do_read(11'd5, 8'h00);
    do_read(11'd2047, 8'h00);

    finish_run();
  end
endmodule